// File: doc/BRIEF.md
# Reloading counter/timer channel

This block is a single channel of a multi-channel counter/timer. It holds an 8-bit time constant and an 8-bit down-counter that is loaded from it. In timer mode the counter steps once per prescaler period, the prescaler dividing the system clock by a short or a long power of two. In counter mode it steps once per active edge of an external, asynchronous clock/trigger input, after that input has been synchronized to the system clock. When the count runs out, the counter reloads itself from the time constant without losing a cycle and emits a one-clock zero-count event.

The surrounding chip decodes bus writes into the configuration levels and the time-constant and software-reset strobes seen here. It also takes the zero-count event into its interrupt arbitration, and reads the live count straight from the count output. A timer can start on its own when its constant is written, or wait for an external trigger edge. A change of the selected edge polarity counts as an active edge. A constant written while the channel runs takes effect only at the next zero count.

Top module: `rtmr_channel`

## Requirements
- R1: The time constant is 8 bits wide; the value 0x00 means 256, so a channel loaded with 0 produces one zero-count event every 256 decrements, and the count output reads 0x00 directly after such a reload.
- R2: In timer mode the counter steps once every P system clocks, where P = 2^PRE_LO_LOG when cfg_pre_long=0 and P = 2^PRE_HI_LOG when cfg_pre_long=1 (16 and 256 by default). The first step comes exactly P clocks after the timer starts, so the first zero count comes after P×T clocks.
- R3: In counter mode (cfg_count_mode=1) each active edge of ext_trig decrements the count by one: a rising edge when cfg_rise_edge=1, a falling edge when cfg_rise_edge=0. The new count is visible after the (SYNC_STAGES+1)-th rising clock edge following the input change.
- R4: A step taken at count 1 reloads the count from the time constant instead of reaching zero, and zc_event is high for exactly that one clock. The count output never reads a value other than one less than before, the reload value, or a freshly written constant.
- R5: A time constant written while the channel is running does not change the current count; it is used at the next reload, including a write that lands in the same clock as that reload.
- R6: A time-constant write to a stopped channel loads the count at once. In timer mode with cfg_ext_start=0 the timer starts on that write. With cfg_ext_start=1 the channel stays pending, with its count frozen, until an active ext_trig edge starts it.
- R7: Changing cfg_rise_edge while the channel runs or is pending acts as one active edge: a pending timer starts and a running counter decrements.
- R8: A sw_rst pulse stops the channel and freezes the count output; the channel stays stopped, ignoring triggers and producing no zero-count event, until the next time-constant write, which reloads the count and restarts it.
- R9: While rst is high the count output is 0 and zc_event and zc_to are low. After rst the channel stays stopped, with its count at 0, until a time constant is written.
- R10: With HAS_ZC_OUT=1, zc_to follows zc_event. With HAS_ZC_OUT=0, zc_to stays low while zc_event still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| cfg_count_mode | input | 1 | 1 = counter mode, 0 = timer mode |
| cfg_pre_long | input | 1 | Timer divider select: 1 = long, 0 = short |
| cfg_rise_edge | input | 1 | Active edge of ext_trig: 1 = rising, 0 = falling |
| cfg_ext_start | input | 1 | Timer start: 1 = wait for trigger edge, 0 = on constant write |
| tc_wr | input | 1 | One-clock strobe writing tc_data as the time constant |
| tc_data | input | CNT_W | Time constant value (0 means 2^CNT_W) |
| sw_rst | input | 1 | One-clock software reset strobe |
| ext_trig | input | 1 | Asynchronous external clock/trigger input |
| count_o | output | CNT_W | Live count value |
| zc_event | output | 1 | One-clock zero-count event for the interrupt logic |
| zc_to | output | 1 | One-clock zero-count output pulse |

## Verification
The bench builds the main instance with PRE_LO_LOG=2 and PRE_HI_LOG=3, so the divide-by-4 and divide-by-8 timers reach several full P×T intervals, the exact first-step cycle and repeated reloads within a few dozen clocks. The 8-bit count width stays at its default, which keeps the 0-means-256 constant and a full 256-edge wrap within reach in counter mode. A second instance built with HAS_ZC_OUT=0 is driven with the same stimulus, so the suppressed output pin is compared against live zero-count events.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

    // Channel run state
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,   // stopped, waiting for a time constant
        CH_PEND = 2'd1,   // constant loaded, timer waiting for its trigger
        CH_RUN  = 2'd2    // counting
    } ch_state_e;

    // Decoded configuration levels
    typedef struct packed {
        logic count_mode;
        logic pre_long;
        logic rise;
        logic ext_start;
    } ch_cfg_t;

    // Channel should wait for a trigger after a constant write
    function automatic logic needs_trigger(input ch_cfg_t cfg);
        return !cfg.count_mode && cfg.ext_start;
    endfunction

endpackage

// File: rtl/rtmr_trig_sync.sv
module rtmr_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic rise,
    output logic act_edge
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pol_q;
    logic                   lvl;
    logic                   pin_edge;

    assign lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            pol_q  <= rise;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
            prev_q <= lvl;
            pol_q  <= rise;
        end
    end

    // Edge on the synchronized pin, per selected polarity
    assign pin_edge = rise ? (lvl && !prev_q) : (!lvl && prev_q);
    // A polarity change also counts as an active edge
    assign act_edge = pin_edge || (rise != pol_q);

endmodule

// File: rtl/rtmr_prescale.sv
module rtmr_prescale #(
    parameter int LO_LOG = 4,
    parameter int HI_LOG = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  logic sel_long,
    output logic tick
);
    localparam int PRE_W = HI_LOG;
    localparam logic [PRE_W-1:0] PRE_ONE = {{(PRE_W-1){1'b0}}, 1'b1};

    logic [PRE_W-1:0] pre_q;
    logic             short_full;
    logic             long_full;

    assign short_full = &pre_q[LO_LOG-1:0];
    assign long_full  = &pre_q;
    assign tick       = en && (sel_long ? long_full : short_full);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (en) begin
            pre_q <= pre_q + PRE_ONE;
        end
    end

endmodule

// File: rtl/rtmr_count.sv
module rtmr_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load_now,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             zc
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] tc_q;
    logic [CNT_W-1:0] reload_val;
    logic             at_one;

    assign at_one = (count == CNT_ONE);
    // A write landing on the reload clock supplies the new value
    assign reload_val = wr ? wr_data : tc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q  <= '0;
            count <= '0;
            zc    <= 1'b0;
        end else begin
            zc <= dec && at_one;
            if (wr) begin
                tc_q <= wr_data;
            end
            if (load_now) begin
                count <= wr_data;
            end else if (dec) begin
                count <= at_one ? reload_val : count - CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
    import rtmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_LO_LOG  = 4,
    parameter int PRE_HI_LOG  = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_ZC_OUT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_count_mode,
    input  logic             cfg_pre_long,
    input  logic             cfg_rise_edge,
    input  logic             cfg_ext_start,
    input  logic             tc_wr,
    input  logic [CNT_W-1:0] tc_data,
    input  logic             sw_rst,
    input  logic             ext_trig,
    output logic [CNT_W-1:0] count_o,
    output logic             zc_event,
    output logic             zc_to
);
    ch_cfg_t   cfg;
    ch_state_e st_q;
    ch_state_e st_d;
    logic      act_edge;
    logic      wr_ok;
    logic      load_now;
    logic      pend_go;
    logic      pre_tick;
    logic      running;
    logic      dec;
    logic      zc_q;

    assign cfg = '{count_mode: cfg_count_mode, pre_long: cfg_pre_long,
                   rise: cfg_rise_edge, ext_start: cfg_ext_start};

    rtmr_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .trig_in  (ext_trig),
        .rise     (cfg.rise),
        .act_edge (act_edge)
    );

    // Software reset wins over a write in the same clock
    assign wr_ok    = tc_wr && !sw_rst;
    assign load_now = wr_ok && (st_q != CH_RUN);
    assign pend_go  = (st_q == CH_PEND) && act_edge && !sw_rst && !tc_wr;
    assign running  = (st_q == CH_RUN) && !sw_rst;

    always_comb begin
        st_d = st_q;
        if (sw_rst) begin
            st_d = CH_IDLE;
        end else if (load_now) begin
            st_d = needs_trigger(cfg) ? CH_PEND : CH_RUN;
        end else if (pend_go) begin
            st_d = CH_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    rtmr_prescale #(.LO_LOG(PRE_LO_LOG), .HI_LOG(PRE_HI_LOG)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .en       (running && !cfg.count_mode),
        .clr      (load_now || pend_go),
        .sel_long (cfg.pre_long),
        .tick     (pre_tick)
    );

    assign dec = running && (cfg.count_mode ? act_edge : pre_tick);

    rtmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_ok),
        .wr_data  (tc_data),
        .load_now (load_now),
        .dec      (dec),
        .count    (count_o),
        .zc       (zc_q)
    );

    assign zc_event = zc_q;

    generate
        if (HAS_ZC_OUT) begin : g_zc_pin
            assign zc_to = zc_q;
        end else begin : g_zc_none
            assign zc_to = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rtmr_channel_chk.sv
module rtmr_channel_chk
    import rtmr_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter bit HAS_ZC_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             tc_wr,
    input logic [CNT_W-1:0] count_o,
    input logic             zc_event,
    input logic             zc_to,
    input ch_state_e        st
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R9: reset clears the outputs
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !zc_event && !zc_to));

    // R4: a zero-count event follows a step from count 1
    a_r4_zero_from_one: assert property (@(posedge clk) disable iff (rst)
        zc_event |-> ($past(count_o) == ONE));

    // R4: count moves only by one step, a reload or a write
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(count_o) |-> ((count_o == $past(count_o) - ONE) || zc_event || $past(tc_wr)));

    // R8: a stopped channel holds its count until written
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (st == CH_IDLE && !tc_wr) |=> $stable(count_o));

    // R6: a pending timer holds its count
    a_r6_pend_hold: assert property (@(posedge clk) disable iff (rst)
        (st == CH_PEND && !tc_wr) |=> $stable(count_o));

    // R10: output pin follows the event or stays low
    a_r10_zc_out: assert property (@(posedge clk) disable iff (rst)
        zc_to == (HAS_ZC_OUT ? zc_event : 1'b0));

endmodule

bind rtmr_channel rtmr_channel_chk #(.CNT_W(CNT_W), .HAS_ZC_OUT(HAS_ZC_OUT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tc_wr    (tc_wr),
    .count_o  (count_o),
    .zc_event (zc_event),
    .zc_to    (zc_to),
    .st       (st_q)
);

// File: tb/rtmr_channel_tb.sv
`timescale 1ns/1ps
module rtmr_channel_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_count_mode = 1'b0;
    logic       cfg_pre_long = 1'b0;
    logic       cfg_rise_edge = 1'b1;
    logic       cfg_ext_start = 1'b0;
    logic       tc_wr = 1'b0;
    logic [7:0] tc_data = 8'd0;
    logic       sw_rst = 1'b0;
    logic       ext_trig = 1'b0;
    logic [7:0] count_o;
    logic       zc_event;
    logic       zc_to;
    logic [7:0] nz_count;
    logic       nz_event;
    logic       nz_to;

    int n_chk = 0;
    int n_err = 0;
    int zc_seen = 0;
    int zcto_seen = 0;
    int nz_evt_seen = 0;
    int nz_to_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtmr_channel #(.PRE_LO_LOG(2), .PRE_HI_LOG(3)) u_dut (
        .clk(clk), .rst(rst), .cfg_count_mode(cfg_count_mode),
        .cfg_pre_long(cfg_pre_long), .cfg_rise_edge(cfg_rise_edge),
        .cfg_ext_start(cfg_ext_start), .tc_wr(tc_wr), .tc_data(tc_data),
        .sw_rst(sw_rst), .ext_trig(ext_trig), .count_o(count_o),
        .zc_event(zc_event), .zc_to(zc_to)
    );

    rtmr_channel #(.PRE_LO_LOG(2), .PRE_HI_LOG(3), .HAS_ZC_OUT(1'b0)) u_dut_nozc (
        .clk(clk), .rst(rst), .cfg_count_mode(cfg_count_mode),
        .cfg_pre_long(cfg_pre_long), .cfg_rise_edge(cfg_rise_edge),
        .cfg_ext_start(cfg_ext_start), .tc_wr(tc_wr), .tc_data(tc_data),
        .sw_rst(sw_rst), .ext_trig(ext_trig), .count_o(nz_count),
        .zc_event(nz_event), .zc_to(nz_to)
    );

    // Pulse monitor: samples values held before each rising edge
    always @(posedge clk) begin
        if (!rst) begin
            if (zc_event) zc_seen++;
            if (zc_to) zcto_seen++;
            if (nz_event) nz_evt_seen++;
            if (nz_to) nz_to_seen++;
        end
    end

    // {time constant, number of counter-mode edges}
    localparam int N_VEC = 7;
    localparam int VEC_TBL [0:N_VEC-1][0:1] = '{
        '{5, 3}, '{5, 5}, '{5, 12}, '{1, 4}, '{0, 3}, '{0, 256}, '{200, 201}
    };

    function automatic int exp_count(int tc, int n);
        int teff = (tc == 0) ? 256 : tc;
        int r = n % teff;
        return (r == 0) ? tc : teff - r;
    endfunction

    function automatic int exp_zc(int tc, int n);
        int teff = (tc == 0) ? 256 : tc;
        return n / teff;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tc_wr = 1'b0;
        sw_rst = 1'b0;
        ext_trig = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    task automatic wr_tc(int v);
        tc_data = v[7:0];
        tc_wr = 1'b1;
        step(1);
        tc_wr = 1'b0;
    endtask

    task automatic pulse();
        ext_trig = 1'b1;
        step(3);
        ext_trig = 1'b0;
        step(3);
    endtask

    initial begin
        int base;
        int base_to;
        step(3);
        chk("R9 reset count", int'(count_o), 0);
        chk("R9 reset zc_event", int'(zc_event), 0);
        chk("R9 reset zc_to", int'(zc_to), 0);
        do_reset();

        // Table walk: counter mode, rising edges
        for (int i = 0; i < N_VEC; i++) begin
            cfg_count_mode = 1'b1;
            cfg_rise_edge = 1'b1;
            cfg_ext_start = 1'b0;
            do_reset();
            wr_tc(VEC_TBL[i][0]);
            base = zc_seen;
            base_to = zcto_seen;
            for (int k = 0; k < VEC_TBL[i][1]; k++) pulse();
            chk("R3/R1 table count", int'(count_o), exp_count(VEC_TBL[i][0], VEC_TBL[i][1]));
            chk("R4/R1 table zero events", zc_seen - base, exp_zc(VEC_TBL[i][0], VEC_TBL[i][1]));
            chk("R10 table zc_to pulses", zcto_seen - base_to, exp_zc(VEC_TBL[i][0], VEC_TBL[i][1]));
        end

        // R3: falling-edge counting and latency
        cfg_count_mode = 1'b1;
        cfg_rise_edge = 1'b0;
        ext_trig = 1'b1;
        rst = 1'b1;
        step(6);
        rst = 1'b0;
        step(1);
        wr_tc(9);
        ext_trig = 1'b0;
        step(2);
        chk("R3 falling edge not yet seen", int'(count_o), 9);
        step(1);
        chk("R3 falling edge counted", int'(count_o), 8);
        ext_trig = 1'b1;
        step(5);
        chk("R3 rising edge ignored", int'(count_o), 8);

        // R2/R6: auto-start timer, short divider (P=4), T=3
        cfg_count_mode = 1'b0;
        cfg_pre_long = 1'b0;
        cfg_rise_edge = 1'b1;
        cfg_ext_start = 1'b0;
        do_reset();
        wr_tc(3);
        chk("R6 auto load", int'(count_o), 3);
        step(3);
        chk("R2 short before first step", int'(count_o), 3);
        step(1);
        chk("R2 short first step", int'(count_o), 2);
        step(7);
        chk("R2 count before zero", int'(count_o), 1);
        chk("R4 no early event", int'(zc_event), 0);
        step(1);
        chk("R4 event at P*T", int'(zc_event), 1);
        chk("R4 reloaded value", int'(count_o), 3);
        step(1);
        chk("R4 event one clock", int'(zc_event), 0);

        // R2: long divider (P=8), T=2
        cfg_pre_long = 1'b1;
        do_reset();
        wr_tc(2);
        step(7);
        chk("R2 long before first step", int'(count_o), 2);
        step(1);
        chk("R2 long first step", int'(count_o), 1);
        step(8);
        chk("R2 long zero event", int'(zc_event), 1);

        // R6: triggered timer start
        cfg_pre_long = 1'b0;
        cfg_ext_start = 1'b1;
        do_reset();
        wr_tc(2);
        base = zc_seen;
        step(20);
        chk("R6 pending holds count", int'(count_o), 2);
        chk("R6 pending no event", zc_seen - base, 0);
        ext_trig = 1'b1;
        step(6);
        chk("R6 started, before step", int'(count_o), 2);
        step(1);
        chk("R6 first step after trigger", int'(count_o), 1);
        ext_trig = 1'b0;

        // R7: polarity change starts a pending timer
        cfg_rise_edge = 1'b1;
        do_reset();
        wr_tc(5);
        step(2);
        cfg_rise_edge = 1'b0;
        step(4);
        chk("R7 pending started, before step", int'(count_o), 5);
        step(1);
        chk("R7 pending started, stepped", int'(count_o), 4);

        // R7: polarity change decrements a running counter
        cfg_count_mode = 1'b1;
        cfg_rise_edge = 1'b1;
        cfg_ext_start = 1'b0;
        do_reset();
        wr_tc(6);
        step(2);
        chk("R7 counter before change", int'(count_o), 6);
        cfg_rise_edge = 1'b0;
        step(1);
        chk("R7 counter decremented", int'(count_o), 5);
        step(3);
        chk("R7 single decrement", int'(count_o), 5);

        // R5: new constant while running waits for zero
        cfg_rise_edge = 1'b1;
        do_reset();
        wr_tc(3);
        pulse();
        wr_tc(7);
        chk("R5 count kept on write", int'(count_o), 2);
        pulse();
        chk("R5 counting continues", int'(count_o), 1);
        base = zc_seen;
        pulse();
        chk("R5 new constant at reload", int'(count_o), 7);
        chk("R5 zero event", zc_seen - base, 1);

        // R8: software reset freezes, write restarts
        cfg_count_mode = 1'b0;
        cfg_pre_long = 1'b0;
        do_reset();
        wr_tc(10);
        step(5);
        chk("R8 running before reset", int'(count_o), 9);
        sw_rst = 1'b1;
        step(1);
        sw_rst = 1'b0;
        base = zc_seen;
        step(30);
        pulse();
        chk("R8 count frozen", int'(count_o), 9);
        chk("R8 no event while stopped", zc_seen - base, 0);
        wr_tc(4);
        chk("R8 reload on write", int'(count_o), 4);
        step(4);
        chk("R8 restarted", int'(count_o), 3);

        // R9: hardware reset mid-run, stays stopped
        cfg_count_mode = 1'b1;
        do_reset();
        wr_tc(8);
        pulse();
        do_reset();
        chk("R9 mid-run reset count", int'(count_o), 0);
        chk("R9 mid-run reset event", int'(zc_event), 0);
        pulse();
        chk("R9 idle after reset", int'(count_o), 0);

        // R10: instance without output pin
        step(2);
        chk("R10 nozc pin silent", nz_to_seen, 0);
        chk("R10 nozc events match", nz_evt_seen, zc_seen);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got expired expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule